// File: doc/BRIEF.md
# Iterative Shift-Add Unsigned Multiplier

This block multiplies two unsigned 32-bit operands and returns their full 64-bit product. It handles one multiplier bit per clock and uses a single 32-bit adder. The multiplier operand is loaded into the lower half of the 64-bit product register. On each step the lowest bit of that register decides whether the captured multiplicand is added to the upper half. The whole register then shifts right by one place, and the carry out of the adder enters at the top.

A one-cycle `start` while the block is idle captures both operands. `busy` then stays high for 32 steps. After the last step `done` is high for exactly one cycle and `busy` falls. The upper product word appears on `hi` and the lower word on `lo`. Both hold their value until the next accepted start. A new start may be issued in the same cycle in which `done` is high.

Top module: `shift_add_mul`

## Requirements
- R1: While reset is held low and in the first cycle after it, `busy` and `done` are 0 and `hi` and `lo` are 0.
- R2: A `start` sampled high at a clock edge while `busy` is low captures `mcand` and `mplier`, and `busy` is high after that edge.
- R3: After completion, {`hi`,`lo`} equals the unsigned product `mcand` × `mplier` of the captured operands, with `hi` the upper 32 bits and `lo` the lower 32 bits.
- R4: `done` is first high after the 32nd clock edge following the edge that accepted the start, so each multiplier bit takes exactly one step.
- R5: `done` is high for a single cycle, and `busy` is low whenever `done` is high.
- R6: A `start` sampled while `busy` is high is ignored. The running operation keeps its operands and its timing.
- R7: The carry out of the 32-bit addition is kept. With both operands at 0xFFFFFFFF the result is hi=0xFFFFFFFE and lo=0x00000001.
- R8: While idle and without a new start, `hi` and `lo` keep the last result.
- R9: Changes on `mcand` and `mplier` after the start has been accepted do not affect the result.
- R10: During a step in which the lowest product bit is 0, the register shifts right by one place and nothing is added.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Requests an operation; honoured only while idle |
| mcand | input | 32 | Multiplicand operand |
| mplier | input | 32 | Multiplier operand |
| busy | output | 1 | High while the 32 steps run |
| done | output | 1 | One-cycle pulse when the product is ready |
| hi | output | 32 | Upper word of the product |
| lo | output | 32 | Lower word of the product |

## Verification
The embedded properties assume that `start` is a synchronous signal. They also assume that the operands matter only in the cycle in which a start is accepted. They do not assume that `start` is held off while busy, so a start pulse during a run is legal stimulus.

The bench drives inputs only on falling edges. It issues some starts during runs on purpose and randomises the operands right after each accepted start. This keeps every stimulus within those assumptions while still exercising the ignore and capture rules.

// File: rtl/mul_pkg.sv
// Shared types for the shift-add multiplier.
// Assumes: nothing beyond standard SystemVerilog.
package mul_pkg;
    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_RUN  = 1'b1
    } mul_phase_t;
endpackage

// File: rtl/mul_adder.sv
// Ripple-carry adder of parameterised width with carry output.
// Assumes: operands are unsigned; no carry input is needed.
module mul_adder #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] sum,
    output logic         cout
);
    logic [W:0] c;

    assign c[0] = 1'b0;

    // one full-adder cell per bit position
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign sum[i]  = a[i] ^ b[i] ^ c[i];
        assign c[i+1]  = (a[i] & b[i]) | (c[i] & (a[i] ^ b[i]));
    end

    assign cout = c[W];
endmodule

// File: rtl/mul_ctrl.sv
// Sequencer: accepts a start while idle, runs W steps, then pulses done.
// Assumes: start is synchronous to clk; W is a power of two or any value >= 2.
module mul_ctrl #(
    parameter int W = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic load,
    output logic step,
    output logic busy,
    output logic done
);
    import mul_pkg::*;

    localparam int CW = (W > 1) ? $clog2(W) : 1;
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    mul_phase_t    phase;
    logic [CW-1:0] cnt;

    assign busy = (phase == PH_RUN);
    assign step = busy;
    assign load = start && !busy;

    // phase, step counter and completion pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
            cnt   <= '0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            case (phase)
                PH_IDLE: begin
                    if (start) begin
                        phase <= PH_RUN;
                        cnt   <= '0;
                    end
                end
                default: begin
                    cnt <= cnt + 1'b1;
                    if (cnt == LAST) begin
                        phase <= PH_IDLE;
                        done  <= 1'b1;
                    end
                end
            endcase
        end
    end

    // R2
    start_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (busy && cnt == '0));

    // R5
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R5
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R6
    start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cnt != LAST) |=> (busy && cnt == $past(cnt) + 1'b1));

    // R4
    finish_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cnt == LAST) |=> (done && !busy));
endmodule

// File: rtl/mul_datapath.sv
// Product register with the multiplier in its lower half, plus the multiplicand
// register and one W-bit adder acting on the upper half.
// Assumes: load and step are never high together.
module mul_datapath #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         step,
    input  logic [W-1:0] mcand,
    input  logic [W-1:0] mplier,
    output logic [2*W-1:0] prod
);
    localparam int PW = 2 * W;

    logic [W-1:0] mcand_q;
    logic [W-1:0] addend;
    logic [W-1:0] sum;
    logic         carry;

    assign addend = prod[0] ? mcand_q : '0;

    mul_adder #(.W(W)) u_add (
        .a    (prod[PW-1:W]),
        .b    (addend),
        .sum  (sum),
        .cout (carry)
    );

    // capture the multiplicand on an accepted start
    always_ff @(posedge clk) begin
        if (!rst_n) mcand_q <= '0;
        else if (load) mcand_q <= mcand;
    end

    // load the product register, or add-and-shift it one place right
    always_ff @(posedge clk) begin
        if (!rst_n)    prod <= '0;
        else if (load) prod <= {{W{1'b0}}, mplier};
        else if (step) prod <= {carry, sum, prod[W-1:1]};
    end

    // R8
    prod_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !step) |=> $stable(prod));

    // R10
    zero_bit_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !prod[0]) |=> (prod == ($past(prod) >> 1)));

    // R9
    mcand_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> $stable(mcand_q));
endmodule

// File: rtl/shift_add_mul.sv
// Top of the iterative unsigned multiplier: sequencer plus datapath.
// Assumes: operands are valid in the cycle start is sampled while idle.
module shift_add_mul #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] mcand,
    input  logic [W-1:0] mplier,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] hi,
    output logic [W-1:0] lo
);
    logic         load;
    logic         step;
    logic [2*W-1:0] prod;

    mul_ctrl #(.W(W)) u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .load  (load),
        .step  (step),
        .busy  (busy),
        .done  (done)
    );

    mul_datapath #(.W(W)) u_dp (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (load),
        .step   (step),
        .mcand  (mcand),
        .mplier (mplier),
        .prod   (prod)
    );

    assign hi = prod[2*W-1:W];
    assign lo = prod[W-1:0];

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!busy && !done && hi == '0 && lo == '0));
endmodule

// File: tb/shift_add_mul_test.sv
module shift_add_mul_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        start;
    logic [31:0] mcand;
    logic [31:0] mplier;
    logic        busy;
    logic        done;
    logic [31:0] hi;
    logic [31:0] lo;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;

    logic [63:0] exp_q[$];
    int          cap_q[$];
    logic [63:0] last_exp = '0;
    logic        prev_done = 1'b0;

    shift_add_mul uut (
        .clk(clk), .rst_n(rst_n), .start(start), .mcand(mcand),
        .mplier(mplier), .busy(busy), .done(done), .hi(hi), .lo(lo)
    );

    always #2 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input logic ok, input string req,
                       input logic [63:0] act, input logic [63:0] expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    // driver: issue an accepted start and push the expected item
    task automatic run_op(input logic [31:0] a, input logic [31:0] b);
        while (busy) @(negedge clk);
        start  = 1'b1;
        mcand  = a;
        mplier = b;
        exp_q.push_back({32'b0, a} * {32'b0, b});
        cap_q.push_back(cyc + 1);
        @(negedge clk);
        start  = 1'b0;
        mcand  = $urandom;   // R9: scramble after capture
        mplier = $urandom;
        chk(busy, "R2 busy after start", {63'b0, busy}, 64'd1);
    endtask

    task automatic wait_done();
        @(negedge clk);
        while (!done) @(negedge clk);
    endtask

    // monitor: compare each completed product with the scoreboard
    always @(negedge clk) begin
        if (rst_n === 1'b1) begin
            if (done) begin
                chk(!prev_done, "R5 single-cycle done", {63'b0, prev_done}, 64'd0);
                chk(!busy, "R5 busy low with done", {63'b0, busy}, 64'd0);
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R3 unexpected done", {hi, lo}, 64'd0);
                end else begin
                    logic [63:0] e;
                    int c;
                    e = exp_q.pop_front();
                    c = cap_q.pop_front();
                    chk({hi, lo} == e, "R3 product", {hi, lo}, e);
                    chk(cyc - c == 32, "R4 latency", 64'(cyc - c), 64'd32);
                    last_exp = e;
                end
            end
            prev_done = done;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        chk(1'b0, "watchdog", 64'd0, 64'd0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n  = 1'b0;
        start  = 1'b0;
        mcand  = '0;
        mplier = '0;
        repeat (3) @(negedge clk);
        chk(!busy && !done && hi == 0 && lo == 0, "R1 reset state",
            {hi, lo}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done && hi == 0 && lo == 0, "R1 after reset",
            {hi, lo}, 64'd0);

        run_op(32'h8, 32'h9);                 wait_done();
        run_op(32'h0, 32'hFFFF_FFFF);         wait_done();
        // R7: full-scale operands exercise the carry out
        run_op(32'hFFFF_FFFF, 32'hFFFF_FFFF); wait_done();
        chk({hi, lo} == 64'hFFFF_FFFE_0000_0001, "R7 carry kept",
            {hi, lo}, 64'hFFFF_FFFE_0000_0001);
        run_op(32'hFFFF_FFFF, 32'h1);         wait_done();
        // R10: multiplier with only the top bit set gives 31 no-add steps
        run_op(32'h1, 32'h8000_0000);         wait_done();
        run_op(32'h1234_5678, 32'h9ABC_DEF0);

        // R6: start pulse during a run must be ignored
        repeat (5) @(negedge clk);
        start = 1'b1; mcand = 32'hDEAD_BEEF; mplier = 32'h0000_0003;
        @(negedge clk);
        start = 1'b0;
        chk(busy, "R6 run continues", {63'b0, busy}, 64'd1);
        wait_done();

        // R8: result holds while idle
        repeat (6) @(negedge clk);
        chk({hi, lo} == last_exp && !busy, "R8 result held", {hi, lo}, last_exp);

        // back-to-back: start in the cycle done is high
        run_op(32'h0000_FFFF, 32'h0001_0001); wait_done();
        run_op(32'h7, 32'h3);                 wait_done();
        for (int i = 0; i < 6; i++) begin
            run_op($urandom, $urandom);
            wait_done();
        end

        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0, "R3 all results seen", 64'(exp_q.size()), 64'd0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule